// File: doc/BRIEF.md
# Dual-Port Byte-Lane RAM with Selectable Read Latency

This block is a behavioural true dual-port synchronous memory. Two ports, called left and right, each carry their own address, data input, a two-signal chip select, a read/write line and an active-low select for each byte lane. Either port can read or write any word in any cycle, and both ports may reach the same word in the same cycle. A word is 18 bits wide and is split into an upper lane (bits 17..9) and a lower lane (bits 8..0). Each lane can be written or driven on its own.

Each port has a static mode input that picks its read latency. Flow-through mode shows the word one edge after the request. Pipelined mode adds one more register stage. In place of tri-state pins, each port gives out a per-lane drive-enable beside its data output. An output-enable input switches that drive off at once, without waiting for a clock edge. The address comes from outside the block. The default depth is kept small, and a 16K-word instance uses `ADDR_W = 14`.

Top module: `dpr_dual_port`

## Requirements
- R1: A port is selected only while its `ce_lo_n` is 0 and its `ce_hi` is 1. Sampled with any other combination, it writes nothing and starts no read.
- R2: A selected write (`rw_n` = 0) stores `din[17:9]` when `ub_n` = 0 and `din[8:0]` when `lb_n` = 0. A lane whose select is 1 keeps its old contents.
- R3: With `ub_n` and `lb_n` both 1, a selected cycle writes nothing, and a read drives neither lane (`drive` = 2'b00).
- R4: `drive[1]` belongs to the upper lane and `drive[0]` to the lower lane. A read drives only the lanes whose select was 0. A lane that is not driven reads as zero on `dout`. While `oe_n` is 1, `drive` is 2'b00 at once, with no clock edge needed.
- R5: With `pipe` = 0 (flow-through), the word at the address sampled at edge n is on `dout` right after edge n.
- R6: With `pipe` = 1 (pipelined), that word appears after edge n+1, and the drive is low after edge n.
- R7: After a port is deselected at edge k, its drive goes low after edge k in flow-through mode and after edge k+1 in pipelined mode. A lane select sampled at edge k acts on the drive after edge k in both modes.
- R8: When one port writes a word that the other port reads at the same edge, the read returns the old contents. The next read returns the new contents.
- R9: When both ports write the same word at the same edge, each lane the left port writes takes the left data. A lane written only by the right port takes the right data.
- R10: A write cycle does not drive the outputs (`drive` = 2'b00 after that edge in flow-through mode).
- R11: After synchronous reset (`rst_n` = 0), both ports show `drive` = 2'b00 until a read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports, rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the output staging |
| l_addr | input | ADDR_W | Left port word address |
| l_ce_lo_n | input | 1 | Left chip select, active low |
| l_ce_hi | input | 1 | Left chip select, active high |
| l_rw_n | input | 1 | Left read (1) or write (0) |
| l_ub_n | input | 1 | Left upper-lane select, active low |
| l_lb_n | input | 1 | Left lower-lane select, active low |
| l_oe_n | input | 1 | Left output enable, active low, acts without a clock |
| l_pipe | input | 1 | Left read mode: 0 flow-through, 1 pipelined |
| l_din | input | 2*LANE_W | Left write data |
| l_dout | output | 2*LANE_W | Left read data, lanes that are not driven are zero |
| l_drive | output | 2 | Left per-lane drive enable {upper, lower} |
| r_addr | input | ADDR_W | Right port word address |
| r_ce_lo_n | input | 1 | Right chip select, active low |
| r_ce_hi | input | 1 | Right chip select, active high |
| r_rw_n | input | 1 | Right read (1) or write (0) |
| r_ub_n | input | 1 | Right upper-lane select, active low |
| r_lb_n | input | 1 | Right lower-lane select, active low |
| r_oe_n | input | 1 | Right output enable, active low, acts without a clock |
| r_pipe | input | 1 | Right read mode: 0 flow-through, 1 pipelined |
| r_din | input | 2*LANE_W | Right write data |
| r_dout | output | 2*LANE_W | Right read data, lanes that are not driven are zero |
| r_drive | output | 2 | Right per-lane drive enable {upper, lower} |

## Verification
Two pairs of functions can fall in the same cycle. A write on one port can meet a read of the same word on the other port, and two writes can hit one word together. The bench provokes the first by having the left port write a fresh value while the right port reads that word at the same edge. It expects the old value at that edge and the new value on the following read. It provokes the second with full-word and lower-lane-only writes from the left port against full-word writes from the right port. It logs each collision and compares the stored word lane by lane with the left-wins rule.

// File: rtl/dpr_pkg.sv
// Package dpr_pkg
// Shared types and helpers for the dual-port RAM. It assumes that
// chip selects and lane selects come in already synchronous to clk.
package dpr_pkg;

    // Read latency mode of one port
    typedef enum logic {
        MODE_FLOW = 1'b0,
        MODE_PIPE = 1'b1
    } rd_mode_e;

    // A port is selected only with the low-active select low and the high-active select high
    function automatic logic port_selected(input logic ce_lo_n, input logic ce_hi);
        return (!ce_lo_n) && ce_hi;
    endfunction

endpackage

// File: rtl/dpr_store.sv
// Module dpr_store
// Word storage with two synchronous access ports and per-lane write
// enables. Read data is registered at the edge where the request is
// sampled and always returns the contents from before that edge. When
// both ports write one lane of one word at the same edge, port A wins.
// It assumes that both ports share a single clock.
module dpr_store #(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [LANES-1:0]          a_we,
    input  logic                      a_rd,
    input  logic [ADDR_W-1:0]         a_addr,
    input  logic [LANES*LANE_W-1:0]   a_wdata,
    output logic [LANES*LANE_W-1:0]   a_rdata,
    input  logic [LANES-1:0]          b_we,
    input  logic                      b_rd,
    input  logic [ADDR_W-1:0]         b_addr,
    input  logic [LANES*LANE_W-1:0]   b_wdata,
    output logic [LANES*LANE_W-1:0]   b_rdata
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int WORD_W = LANES * LANE_W;

    logic [WORD_W-1:0] mem [DEPTH];

    // Lane writes: port B first, then port A, so A's nonblocking update lands last
    always_ff @(posedge clk) begin
        for (int i = 0; i < LANES; i++) begin
            if (b_we[i]) mem[b_addr][i*LANE_W +: LANE_W] <= b_wdata[i*LANE_W +: LANE_W];
        end
        for (int i = 0; i < LANES; i++) begin
            if (a_we[i]) mem[a_addr][i*LANE_W +: LANE_W] <= a_wdata[i*LANE_W +: LANE_W];
        end
    end

    // Read registers: capture the word from before this edge on a read, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_rdata <= '0;
            b_rdata <= '0;
        end else begin
            if (a_rd) a_rdata <= mem[a_addr];
            if (b_rd) b_rdata <= mem[b_addr];
        end
    end

    // R9: on a lower-lane write collision the stored lane holds port A's data
    a_r9_left_lane_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (a_we[0] && b_we[0] && a_addr == b_addr)
        |=> mem[$past(a_addr)][LANE_W-1:0] == $past(a_wdata[LANE_W-1:0]));

    // R8: port B reading a word that port A writes at that edge sees the old contents
    a_r8_read_old_word: assert property (@(posedge clk) disable iff (!rst_n)
        (b_rd && a_we != '0 && a_addr == b_addr)
        |=> b_rdata == $past(mem[b_addr]));

endmodule

// File: rtl/dpr_port.sv
// Module dpr_port
// Front end of one port. It decodes the select, read/write and lane
// pins into store requests and stages the returned word in the chosen
// read mode. Lane selects are registered once. The read qualifier,
// which carries the chip select, is registered once in flow-through
// mode and twice in pipelined mode. Output enable gates the drive with
// no register in the path. It assumes that pipe changes only while the
// port is idle.
module dpr_port
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         addr,
    input  logic                      ce_lo_n,
    input  logic                      ce_hi,
    input  logic                      rw_n,
    input  logic [LANES-1:0]          lane_n,
    input  logic                      oe_n,
    input  logic                      pipe,
    input  logic [LANES*LANE_W-1:0]   din,
    output logic [LANES-1:0]          st_we,
    output logic                      st_rd,
    output logic [ADDR_W-1:0]         st_addr,
    output logic [LANES*LANE_W-1:0]   st_wdata,
    input  logic [LANES*LANE_W-1:0]   st_rdata,
    output logic [LANES*LANE_W-1:0]   dout,
    output logic [LANES-1:0]          drive
);
    localparam int WORD_W = LANES * LANE_W;

    rd_mode_e          mode;
    logic              sel;
    logic              rd_q1, rd_q2;
    logic [LANES-1:0]  lane_q;
    logic [WORD_W-1:0] data_q2;
    logic [LANES-1:0]  drv_raw;
    logic [WORD_W-1:0] data_sel;

    // Request decode toward the store
    always_comb begin
        mode     = rd_mode_e'(pipe);
        sel      = port_selected(ce_lo_n, ce_hi);
        st_we    = (sel && !rw_n) ? ~lane_n : '0;
        st_rd    = sel && rw_n;
        st_addr  = addr;
        st_wdata = din;
    end

    // Output staging: read qualifier once or twice, lane selects once, pipelined data once more
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q1   <= 1'b0;
            rd_q2   <= 1'b0;
            lane_q  <= '0;
            data_q2 <= '0;
        end else begin
            rd_q1   <= st_rd;
            rd_q2   <= rd_q1;
            lane_q  <= ~lane_n;
            data_q2 <= st_rdata;
        end
    end

    // Drive and data selection by mode, with output enable applied without a register
    always_comb begin
        if (mode == MODE_PIPE) begin
            drv_raw  = rd_q2 ? lane_q : '0;
            data_sel = data_q2;
        end else begin
            drv_raw  = rd_q1 ? lane_q : '0;
            data_sel = st_rdata;
        end
        drive = oe_n ? '0 : drv_raw;
    end

    // Per-lane zeroing of data that is not driven
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign dout[g*LANE_W +: LANE_W] = drive[g] ? data_sel[g*LANE_W +: LANE_W] : '0;
    end

    // R7: in flow-through mode a deselect at one edge stops the drive after that edge
    a_r7_flow_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel && !pipe) |=> (pipe || drive == '0));

    // R7: in pipelined mode a deselect stops the drive one edge later
    a_r7_pipe_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel && pipe) |-> ##2 (!pipe || drive == '0));

    // R3: a read with no lane selected drives nothing
    a_r3_no_lane_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && rw_n && lane_n == '1 && !pipe) |=> (pipe || drive == '0));

    // R10: a flow-through write cycle leaves the outputs undriven
    a_r10_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !rw_n && !pipe) |=> (pipe || drive == '0));

endmodule

// File: rtl/dpr_dual_port.sv
// Module dpr_dual_port
// Top of the dual-port RAM: two port front ends around one storage
// array. The left port is wired to the store's winning side. It
// assumes a single clock shared by both ports.
module dpr_dual_port #(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     l_addr,
    input  logic                  l_ce_lo_n,
    input  logic                  l_ce_hi,
    input  logic                  l_rw_n,
    input  logic                  l_ub_n,
    input  logic                  l_lb_n,
    input  logic                  l_oe_n,
    input  logic                  l_pipe,
    input  logic [2*LANE_W-1:0]   l_din,
    output logic [2*LANE_W-1:0]   l_dout,
    output logic [1:0]            l_drive,
    input  logic [ADDR_W-1:0]     r_addr,
    input  logic                  r_ce_lo_n,
    input  logic                  r_ce_hi,
    input  logic                  r_rw_n,
    input  logic                  r_ub_n,
    input  logic                  r_lb_n,
    input  logic                  r_oe_n,
    input  logic                  r_pipe,
    input  logic [2*LANE_W-1:0]   r_din,
    output logic [2*LANE_W-1:0]   r_dout,
    output logic [1:0]            r_drive
);
    localparam int LANES  = 2;
    localparam int WORD_W = LANES * LANE_W;

    logic [LANES-1:0]  l_we, r_we;
    logic              l_rd, r_rd;
    logic [ADDR_W-1:0] l_sa, r_sa;
    logic [WORD_W-1:0] l_wd, r_wd, l_rdq, r_rdq;

    dpr_port #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_left (
        .clk(clk), .rst_n(rst_n), .addr(l_addr), .ce_lo_n(l_ce_lo_n), .ce_hi(l_ce_hi),
        .rw_n(l_rw_n), .lane_n({l_ub_n, l_lb_n}), .oe_n(l_oe_n), .pipe(l_pipe), .din(l_din),
        .st_we(l_we), .st_rd(l_rd), .st_addr(l_sa), .st_wdata(l_wd), .st_rdata(l_rdq),
        .dout(l_dout), .drive(l_drive)
    );

    dpr_port #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_right (
        .clk(clk), .rst_n(rst_n), .addr(r_addr), .ce_lo_n(r_ce_lo_n), .ce_hi(r_ce_hi),
        .rw_n(r_rw_n), .lane_n({r_ub_n, r_lb_n}), .oe_n(r_oe_n), .pipe(r_pipe), .din(r_din),
        .st_we(r_we), .st_rd(r_rd), .st_addr(r_sa), .st_wdata(r_wd), .st_rdata(r_rdq),
        .dout(r_dout), .drive(r_drive)
    );

    dpr_store #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_store (
        .clk(clk), .rst_n(rst_n),
        .a_we(l_we), .a_rd(l_rd), .a_addr(l_sa), .a_wdata(l_wd), .a_rdata(l_rdq),
        .b_we(r_we), .b_rd(r_rd), .b_addr(r_sa), .b_wdata(r_wd), .b_rdata(r_rdq)
    );

endmodule

// File: tb/dpr_dual_port_test.sv
module dpr_dual_port_test;
    localparam int AW = 10;
    localparam int W  = 18;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n;
    logic [AW-1:0] l_addr, r_addr;
    logic          l_ce_lo_n, l_ce_hi, l_rw_n, l_ub_n, l_lb_n, l_oe_n, l_pipe;
    logic          r_ce_lo_n, r_ce_hi, r_rw_n, r_ub_n, r_lb_n, r_oe_n, r_pipe;
    logic [W-1:0]  l_din, r_din, l_dout, r_dout;
    logic [1:0]    l_drive, r_drive;

    int  total = 0;
    int  bad = 0;
    int  collisions = 0;
    bit  done = 1'b0;

    dpr_dual_port uut (
        .clk(clk), .rst_n(rst_n),
        .l_addr(l_addr), .l_ce_lo_n(l_ce_lo_n), .l_ce_hi(l_ce_hi), .l_rw_n(l_rw_n),
        .l_ub_n(l_ub_n), .l_lb_n(l_lb_n), .l_oe_n(l_oe_n), .l_pipe(l_pipe),
        .l_din(l_din), .l_dout(l_dout), .l_drive(l_drive),
        .r_addr(r_addr), .r_ce_lo_n(r_ce_lo_n), .r_ce_hi(r_ce_hi), .r_rw_n(r_rw_n),
        .r_ub_n(r_ub_n), .r_lb_n(r_lb_n), .r_oe_n(r_oe_n), .r_pipe(r_pipe),
        .r_din(r_din), .r_dout(r_dout), .r_drive(r_drive)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic l_set(input bit en, input bit wr, input bit ub_n, input bit lb_n,
                         input logic [AW-1:0] a, input logic [W-1:0] d);
        l_ce_lo_n = !en; l_ce_hi = en; l_rw_n = !wr;
        l_ub_n = ub_n; l_lb_n = lb_n; l_addr = a; l_din = d;
    endtask

    task automatic r_set(input bit en, input bit wr, input bit ub_n, input bit lb_n,
                         input logic [AW-1:0] a, input logic [W-1:0] d);
        r_ce_lo_n = !en; r_ce_hi = en; r_rw_n = !wr;
        r_ub_n = ub_n; r_lb_n = lb_n; r_addr = a; r_din = d;
    endtask

    localparam logic [W-1:0] V5 = 18'h2AB5;
    localparam logic [W-1:0] UP = 18'h3FE00;
    localparam logic [W-1:0] LO = 18'h001FF;

    task automatic t_reset();
        chk("R11 left drive after reset", {16'b0, l_drive}, 18'h0);
        chk("R11 right drive after reset", {16'b0, r_drive}, 18'h0);
    endtask

    task automatic t_write_flow_read();
        l_set(1, 1, 0, 0, 10'd5, V5); tick();
        chk("R10 no drive after write", {16'b0, l_drive}, 18'h0);
        l_set(1, 1, 0, 0, 10'd6, 18'h0); tick();
        l_set(1, 1, 1, 0, 10'd6, 18'h3FFFF); tick();
        l_set(1, 1, 0, 0, 10'd7, 18'h0); tick();
        l_set(1, 1, 0, 1, 10'd7, 18'h3FFFF); tick();
        l_set(1, 0, 0, 0, 10'd5, 18'h0); tick();
        chk("R5 flow read data", l_dout, V5);
        chk("R5 flow read drive", {16'b0, l_drive}, 18'h3);
        l_set(1, 0, 0, 0, 10'd6, 18'h0); tick();
        chk("R2 lower-only write", l_dout, LO);
        l_set(1, 0, 0, 0, 10'd7, 18'h0); tick();
        chk("R2 upper-only write", l_dout, UP);
    endtask

    task automatic t_lane_read_oe();
        l_set(1, 0, 0, 1, 10'd5, 18'h0); tick();
        chk("R4 upper-lane read drive", {16'b0, l_drive}, 18'h2);
        chk("R4 upper-lane read data", l_dout, V5 & UP);
        l_set(1, 0, 0, 0, 10'd5, 18'h0); tick();
        l_oe_n = 1'b1; #0.5;
        chk("R4 oe high drive off without clock", {16'b0, l_drive}, 18'h0);
        chk("R4 oe high data zero", l_dout, 18'h0);
        l_oe_n = 1'b0; #0.3;
        chk("R4 oe low drive back", {16'b0, l_drive}, 18'h3);
    endtask

    task automatic t_no_lanes_and_deselect();
        l_set(1, 1, 1, 1, 10'd5, 18'h0); tick();
        l_set(1, 0, 0, 0, 10'd5, 18'h0); tick();
        chk("R3 write with no lanes keeps word", l_dout, V5);
        l_set(1, 0, 1, 1, 10'd5, 18'h0); tick();
        chk("R3 read with no lanes drives nothing", {16'b0, l_drive}, 18'h0);
        l_ce_lo_n = 1'b0; l_ce_hi = 1'b0; l_rw_n = 1'b0; l_ub_n = 1'b0; l_lb_n = 1'b0;
        l_addr = 10'd5; l_din = 18'h0; tick();
        l_ce_lo_n = 1'b1; l_ce_hi = 1'b1; tick();
        l_rw_n = 1'b1; tick();
        chk("R1 deselected read drives nothing", {16'b0, l_drive}, 18'h0);
        l_set(1, 0, 0, 0, 10'd5, 18'h0); tick();
        chk("R1 deselected writes ignored", l_dout, V5);
        l_set(0, 0, 0, 0, 10'd5, 18'h0); tick();
        chk("R7 flow deselect drive off after one edge", {16'b0, l_drive}, 18'h0);
    endtask

    task automatic t_pipe_read();
        r_pipe = 1'b1; r_set(0, 0, 0, 0, 10'd0, 18'h0); tick(); tick();
        r_set(1, 0, 0, 0, 10'd5, 18'h0); tick();
        chk("R6 pipe no drive after first edge", {16'b0, r_drive}, 18'h0);
        r_ce_lo_n = 1'b1; tick();
        chk("R6 pipe data after second edge", r_dout, V5);
        chk("R6 pipe drive after second edge", {16'b0, r_drive}, 18'h3);
        tick();
        chk("R6 pipe drive off after idle", {16'b0, r_drive}, 18'h0);
        r_set(1, 0, 0, 0, 10'd5, 18'h0); tick();
        r_addr = 10'd6; tick();
        chk("R6 pipe back-to-back first word", r_dout, V5);
        r_addr = 10'd7; tick();
        chk("R6 pipe back-to-back second word", r_dout, LO);
        r_addr = 10'd5; tick(); tick();
        r_ce_hi = 1'b0; tick();
        chk("R7 pipe deselect still driven one edge", {16'b0, r_drive}, 18'h3);
        tick();
        chk("R7 pipe deselect off after two edges", {16'b0, r_drive}, 18'h0);
        r_set(1, 0, 0, 0, 10'd5, 18'h0); tick(); tick();
        r_ub_n = 1'b1; tick();
        chk("R7 pipe lane select acts after one edge", {16'b0, r_drive}, 18'h1);
        r_set(0, 0, 0, 0, 10'd0, 18'h0); tick(); tick();
        r_pipe = 1'b0; tick();
    endtask

    task automatic t_read_during_write();
        l_set(1, 1, 0, 0, 10'd9, 18'h15A5A); tick();
        l_set(1, 1, 0, 0, 10'd9, 18'h0A5A5);
        r_set(1, 0, 0, 0, 10'd9, 18'h0); tick();
        chk("R8 same-edge read returns old word", r_dout, 18'h15A5A);
        l_set(0, 0, 0, 0, 10'd0, 18'h0); tick();
        chk("R8 next read returns new word", r_dout, 18'h0A5A5);
        r_set(0, 0, 0, 0, 10'd0, 18'h0);
    endtask

    task automatic t_write_collision();
        l_set(1, 1, 0, 0, 10'd12, 18'h11111);
        r_set(1, 1, 0, 0, 10'd12, 18'h22222); tick();
        collisions++;
        $display("note: write collision %0d at word 12", collisions);
        r_set(0, 0, 0, 0, 10'd0, 18'h0);
        l_set(1, 0, 0, 0, 10'd12, 18'h0); tick();
        chk("R9 full collision left wins", l_dout, 18'h11111);
        l_set(1, 1, 1, 0, 10'd12, 18'h3C0F0);
        r_set(1, 1, 0, 0, 10'd12, 18'h0F3CF); tick();
        collisions++;
        $display("note: write collision %0d at word 12", collisions);
        r_set(0, 0, 0, 0, 10'd0, 18'h0);
        l_set(1, 0, 0, 0, 10'd12, 18'h0); tick();
        chk("R9 mixed collision lane merge", l_dout, (18'h0F3CF & UP) | (18'h3C0F0 & LO));
        l_set(0, 0, 0, 0, 10'd0, 18'h0);
    endtask

    initial begin
        rst_n = 1'b0;
        l_oe_n = 1'b0; r_oe_n = 1'b0; l_pipe = 1'b0; r_pipe = 1'b0;
        l_set(0, 0, 0, 0, 10'd0, 18'h0);
        r_set(0, 0, 0, 0, 10'd0, 18'h0);
        tick(); tick(); tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_write_flow_read();
        t_lane_read_oe();
        t_no_lanes_and_deselect();
        t_pipe_read();
        t_read_during_write();
        t_write_collision();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired before the test finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule